// File: doc/BRIEF.md
# Space-Vector Leg-State Sequencer

This block drives the three leg states of a two-level, three-phase inverter for one switching period at a time. Each leg state is a single bit. A 1 means the upper switch of that leg conducts, and a 0 means the lower switch conducts. An upstream stage supplies a sector number and two active-vector dwell times, counted in clock cycles. The block walks one period of programmable length in a fixed pattern: first the all-low zero vector, then the two active vectors that bound the sector, then the all-high zero vector.

The sector, both dwell times and the period length are captured only at the boundary between periods, so one period is always built from one consistent set of values. If the two dwell times together exceed the period, the block clamps them, flags the period as overflowed and leaves no zero time. A one-cycle pulse marks the first cycle of every period. Dead-time insertion and gate drive are done downstream.

Top module: `svm_leg_sequencer`

## Requirements
- R1: While reset is asserted, and in every cycle that follows a clock edge at which the enable input was low, `legs_o` is 3'b000 and `sync_o` and `ovf_o` are 0.
- R2: `legs_o` is {leg1, leg2, leg3}, with leg1 in bit 2. The active vectors are U1=100, U2=110, U3=010, U4=011, U5=001 and U6=101. The zero vectors are U7=000 and U8=111.
- R3: For sector k in the range 1 to 5, the first active vector is Uk and the second is U(k+1). Sector 6 pairs U6 with U1.
- R4: Let period P, dwell times T1 and T2, and zero time Z = P - T1 - T2. Within a period, U7 is output for floor(Z/2) cycles. Then the first active vector follows for T1 cycles, then the second for T2 cycles. U8 fills the remaining ceil(Z/2) cycles.
- R5: When T1+T2 > P, T1 is clamped to at most P and T2 becomes P minus the clamped T1. `ovf_o` is high for that whole period, and neither U7 nor U8 appears in it.
- R6: The sector, T1, T2 and P are sampled only at the clock edge that starts a period. An input change during a period has no effect until the next period. A value present in the last cycle of a period governs the next period.
- R7: A period lasts P cycles, and `sync_o` is high only in its first cycle. A period input of 0 is treated as 1.
- R8: A sector value of 0 or 7 yields U7 for the whole period, with `ovf_o` low.
- R9: When the enable input is first sampled high, the first period starts at that edge, so `sync_o` is high in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low forces U7 and stops the period counter |
| sector_i | input | 3 | Sector number, 1 to 6 |
| t1_i | input | CNT_W | Dwell time of the first active vector, in cycles |
| t2_i | input | CNT_W | Dwell time of the second active vector, in cycles |
| period_i | input | CNT_W | Period length in cycles |
| legs_o | output | 3 | Leg states {leg1, leg2, leg3} |
| sync_o | output | 1 | High in the first cycle of each period |
| ovf_o | output | 1 | Dwell times were clamped for the current period |

## Verification
Two things can happen at the same clock edge: the period wraps and reloads its parameters, and the upstream stage presents new sector and dwell values. The bench changes the inputs on the falling edge of a period's last cycle. It then checks that this last cycle still shows the old pattern and that the next period follows the new values from its first cycle. In a separate test the inputs change in the middle of a period, and every remaining cycle of that period is compared against the old pattern. The clamp flag is covered the same way: it is set only for a period whose own values overflow and cleared for the period after.

// File: rtl/svm_seq_pkg.sv
package svm_seq_pkg;

   localparam int LEGS = 3;
   typedef logic [LEGS-1:0] legs_t;

   localparam legs_t VEC_ZLO = 3'b000;
   localparam legs_t VEC_ZHI = 3'b111;
   localparam int    N_ACT   = 6;

   function automatic legs_t act_vec(input int unsigned k);
      legs_t v;
      case (k)
         1:       v = 3'b100;
         2:       v = 3'b110;
         3:       v = 3'b010;
         4:       v = 3'b011;
         5:       v = 3'b001;
         6:       v = 3'b101;
         default: v = VEC_ZLO;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/svm_vector_select.sv
module svm_vector_select
   import svm_seq_pkg::*;
(
   input  logic [2:0] sector_i,
   output legs_t      vec_a_o,
   output legs_t      vec_b_o,
   output logic       valid_o
);

   legs_t tbl [N_ACT];

   for (genvar i = 0; i < N_ACT; i++) begin : g_tbl
      assign tbl[i] = act_vec(i + 1);
   end

   always_comb begin
      valid_o = (sector_i >= 3'd1) && (sector_i <= 3'd6);
      vec_a_o = VEC_ZLO;
      vec_b_o = VEC_ZLO;
      if (valid_o) begin
         vec_a_o = tbl[sector_i - 3'd1];
         vec_b_o = (sector_i == 3'd6) ? tbl[0] : tbl[sector_i];
      end
   end

endmodule

// File: rtl/svm_dwell_plan.sv
module svm_dwell_plan #(
   parameter int CNT_W = 12
) (
   input  logic [CNT_W-1:0] period_i,
   input  logic [CNT_W-1:0] t1_i,
   input  logic [CNT_W-1:0] t2_i,
   input  logic             sec_ok_i,
   output logic [CNT_W-1:0] plen_o,
   output logic [CNT_W-1:0] b1_o,
   output logic [CNT_W-1:0] b2_o,
   output logic [CNT_W-1:0] b3_o,
   output logic             ovf_o
);

   localparam int               SUM_W = CNT_W + 1;
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] t1e, t2e, zero;

   always_comb begin
      plen_o = (period_i == '0) ? ONE : period_i;
      sum    = {1'b0, t1_i} + {1'b0, t2_i};
      ovf_o  = sec_ok_i && (sum > {1'b0, plen_o});
      if (!sec_ok_i) begin
         t1e = '0;
         t2e = '0;
      end else if (ovf_o) begin
         t1e = (t1_i > plen_o) ? plen_o : t1_i;
         t2e = plen_o - t1e;
      end else begin
         t1e = t1_i;
         t2e = t2_i;
      end
      zero = plen_o - t1e - t2e;
      // an invalid sector pushes every boundary to the end: all low zero vector
      b1_o = sec_ok_i ? (zero >> 1) : plen_o;
      b2_o = b1_o + t1e;
      b3_o = b2_o + t2e;
   end

endmodule

// File: rtl/svm_period_timer.sv
module svm_period_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [CNT_W-1:0] plen_i,
   output logic             act_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             load_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic             act_q;
   logic [CNT_W-1:0] cnt_q;

   assign load_o = en_i && (!act_q || (cnt_q == plen_i - ONE));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (!en_i) begin
         act_q <= 1'b0;
         cnt_q <= '0;
      end else if (load_o) begin
         act_q <= 1'b1;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + ONE;
      end
   end

   assign act_o = act_q;
   assign cnt_o = cnt_q;

endmodule

// File: rtl/svm_leg_sequencer.sv
module svm_leg_sequencer
   import svm_seq_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic [2:0]       sector_i,
   input  logic [CNT_W-1:0] t1_i,
   input  logic [CNT_W-1:0] t2_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [2:0]       legs_o,
   output logic             sync_o,
   output logic             ovf_o
);

   if (CNT_W < 2 || CNT_W > 30) begin : g_bad_cnt_w
      $error("svm_leg_sequencer: CNT_W must be within 2..30");
   end

   logic             sec_ok, ovf_n, act, load;
   legs_t            vec_a, vec_b;
   logic [CNT_W-1:0] plen_n, b1_n, b2_n, b3_n, cnt;

   logic             ovf_q;
   legs_t            va_q, vb_q;
   logic [2:0]       sec_q;
   logic [CNT_W-1:0] plen_q, b1_q, b2_q, b3_q;

   svm_vector_select u_vsel (
      .sector_i (sector_i),
      .vec_a_o  (vec_a),
      .vec_b_o  (vec_b),
      .valid_o  (sec_ok)
   );

   svm_dwell_plan #(.CNT_W(CNT_W)) u_plan (
      .period_i (period_i),
      .t1_i     (t1_i),
      .t2_i     (t2_i),
      .sec_ok_i (sec_ok),
      .plen_o   (plen_n),
      .b1_o     (b1_n),
      .b2_o     (b2_n),
      .b3_o     (b3_n),
      .ovf_o    (ovf_n)
   );

   svm_period_timer #(.CNT_W(CNT_W)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_i),
      .plen_i (plen_q),
      .act_o  (act),
      .cnt_o  (cnt),
      .load_o (load)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         plen_q <= CNT_W'(1);
         b1_q   <= '0;
         b2_q   <= '0;
         b3_q   <= '0;
         va_q   <= VEC_ZLO;
         vb_q   <= VEC_ZLO;
         ovf_q  <= 1'b0;
         sec_q  <= '0;
      end else if (load) begin
         plen_q <= plen_n;
         b1_q   <= b1_n;
         b2_q   <= b2_n;
         b3_q   <= b3_n;
         va_q   <= vec_a;
         vb_q   <= vec_b;
         ovf_q  <= ovf_n;
         sec_q  <= sector_i;
      end
   end

   always_comb begin
      if (!act)             legs_o = VEC_ZLO;
      else if (cnt < b1_q)  legs_o = VEC_ZLO;
      else if (cnt < b2_q)  legs_o = va_q;
      else if (cnt < b3_q)  legs_o = vb_q;
      else                  legs_o = VEC_ZHI;
   end

   assign sync_o = act && (cnt == '0);
   assign ovf_o  = act && ovf_q;

endmodule

// File: rtl/svm_leg_sequencer_chk.sv
module svm_leg_sequencer_chk #(
   parameter int CNT_W = 12
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             en_i,
   input logic [2:0]       legs_o,
   input logic             sync_o,
   input logic             ovf_o,
   input logic             act_i,
   input logic [2:0]       sec_q_i,
   input logic [CNT_W-1:0] plen_q_i
);

   // R1: a low enable forces the all-low vector and clears the flags
   p_idle_zlo_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i |=> (legs_o == 3'b000 && !sync_o && !ovf_o));

   // R5: a clamped period has no zero-vector time
   p_no_overflow_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_o |-> (legs_o != 3'b000 && legs_o != 3'b111));

   // R6: latched sector and period stay put inside a period
   p_latch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (act_i && !sync_o) |-> ($stable(sec_q_i) && $stable(plen_q_i)));

   // R7: the start pulse lasts one cycle unless the period is one cycle
   p_sync_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_o && plen_q_i != CNT_W'(1)) |=> !sync_o);

   // R9: enabling from idle starts a period at once
   p_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (en_i && !act_i) |=> sync_o);

endmodule

bind svm_leg_sequencer svm_leg_sequencer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .en_i     (en_i),
   .legs_o   (legs_o),
   .sync_o   (sync_o),
   .ovf_o    (ovf_o),
   .act_i    (act),
   .sec_q_i  (sec_q),
   .plen_q_i (plen_q)
);

// File: tb/svm_leg_sequencer_tb.sv
`timescale 1ns/1ps
module svm_leg_sequencer_tb;

   localparam int CNT_W = 12;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             en = 1'b0;
   logic [2:0]       sec = '0;
   logic [CNT_W-1:0] t1 = '0, t2 = '0, per = '0;
   logic [2:0]       legs;
   logic             sync, ovf;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   svm_leg_sequencer #(.CNT_W(CNT_W)) u_dut (
      .clk_i (clk), .rst_ni (rst_n), .en_i (en),
      .sector_i (sec), .t1_i (t1), .t2_i (t2), .period_i (per),
      .legs_o (legs), .sync_o (sync), .ovf_o (ovf)
   );

   function automatic int vec_of(int k);
      case (k)
         1: return 3'b100;
         2: return 3'b110;
         3: return 3'b010;
         4: return 3'b011;
         5: return 3'b001;
         6: return 3'b101;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_leg(int s, int a, int b, int p, int c);
      int z, h;
      if (p == 0) p = 1;
      if (s < 1 || s > 6) return 0;
      if (a + b > p) begin
         if (a > p) a = p;
         b = p - a;
      end
      z = p - a - b;
      h = z / 2;
      if (c < h) return 0;
      if (c < h + a) return vec_of(s);
      if (c < h + a + b) return vec_of(s % 6 + 1);
      return 7;
   endfunction

   function automatic bit exp_ovf(int s, int a, int b, int p);
      if (p == 0) p = 1;
      return (s >= 1 && s <= 6) && (a + b > p);
   endfunction

   task automatic chk(bit ok, string req, string what, int act, int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic set_in(int s, int a, int b, int p);
      sec = 3'(s);
      t1  = CNT_W'(a);
      t2  = CNT_W'(b);
      per = CNT_W'(p);
   endtask

   task automatic wait_sync(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!sync && n < 5000);
   endtask

   // checks one whole period; optionally changes inputs mid-period
   task automatic check_period(int s, int a, int b, int p, string req,
                               int exp_wait = 0, int chg_at = -1,
                               int ns = 0, int na = 0, int nb = 0, int np = 0);
      int n, pe, e;
      wait_sync(n);
      if (exp_wait > 0) chk(n == exp_wait, req, "cycles to first sync", n, exp_wait);
      pe = (p == 0) ? 1 : p;
      for (int c = 0; c < pe; c++) begin
         if (c > 0) @(negedge clk);
         e = exp_leg(s, a, b, p, c);
         chk(int'(legs) == e, req, $sformatf("legs cycle %0d", c), legs, e);
         chk(sync == (c == 0), req, $sformatf("sync cycle %0d", c), sync, c == 0);
         chk(ovf == exp_ovf(s, a, b, p), req, $sformatf("ovf cycle %0d", c),
             ovf, exp_ovf(s, a, b, p));
         if (c == chg_at) set_in(ns, na, nb, np);
      end
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      chk(legs == 3'b000, "R1", "legs in reset", legs, 0);
      chk(!sync && !ovf, "R1", "flags in reset", {sync, ovf}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(legs == 3'b000, "R1", "legs idle", legs, 0);
   endtask

   task automatic test_sectors();
      set_in(1, 5, 7, 20);
      en = 1'b1;
      check_period(1, 5, 7, 20, "R4 R9", 1);
      for (int s = 2; s <= 6; s++) begin
         set_in(s, 3, 4, 12);     // applied in last cycle: R6 boundary case
         check_period(s, 3, 4, 12, "R2 R3 R6");
      end
   endtask

   task automatic test_midperiod();
      set_in(3, 2, 2, 16);
      check_period(3, 2, 2, 16, "R6", 0, 5, 1, 9, 9, 30);
      check_period(1, 9, 9, 30, "R6");
   endtask

   task automatic test_odd_zero();
      set_in(5, 2, 2, 11);
      check_period(5, 2, 2, 11, "R4");
   endtask

   task automatic test_overflow();
      set_in(2, 7, 6, 10);
      check_period(2, 7, 6, 10, "R5");
      set_in(4, 15, 3, 10);
      check_period(4, 15, 3, 10, "R5");
      set_in(6, 1, 1, 8);
      check_period(6, 1, 1, 8, "R5");
   endtask

   task automatic test_invalid();
      set_in(0, 3, 3, 8);
      check_period(0, 3, 3, 8, "R8");
      set_in(7, 5, 9, 6);
      check_period(7, 5, 9, 6, "R8");
   endtask

   task automatic test_zero_period();
      set_in(1, 0, 0, 0);
      for (int i = 0; i < 3; i++) check_period(1, 0, 0, 0, "R7");
   endtask

   task automatic test_enable();
      int n;
      set_in(2, 7, 6, 10);
      wait_sync(n);
      @(negedge clk);
      en = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk(legs == 3'b000, "R1", "legs with enable low", legs, 0);
         chk(!sync && !ovf, "R1", "flags with enable low", {sync, ovf}, 0);
      end
      set_in(4, 3, 3, 9);
      en = 1'b1;
      check_period(4, 3, 3, 9, "R9", 1);
   endtask

   initial begin
      test_reset();
      test_sectors();
      test_midperiod();
      test_odd_zero();
      test_overflow();
      test_invalid();
      test_zero_period();
      test_enable();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

   initial begin
      #(4 * 200000);
      if (!done) begin
         done = 1'b1;
         nchk++;
         nfail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end

endmodule